// File: doc/BRIEF.md
# Serial EEPROM Slave Controller with Block Write Protection

This block is the serial-bus front end of a small byte-addressable non-volatile store. It sits behind four pins: serial clock, active-low select, serial data in and active-low pause. It drives one serial data out pin and its enable. The block oversamples the pins with the system clock. It decodes an opcode byte, an address byte and data bytes, and drives read data or status back out. It also keeps a write-enable latch, a busy flag and two protection bits in a status byte.

A store operation is never done straight from the bus. Data bytes first collect in a page buffer. A programming cycle starts only if the select line is released exactly on a byte boundary, the write-enable latch is set, and the target is outside the protected region. The programming cycle is a counter of `WC_CYCLES` system clocks. When it expires, every buffered byte, or the new protection bits, are committed at once. While the cycle runs, commands that would read or change the store are dropped. The status byte can still be read.

Top module: `eeprom_spi_ctrl`

## Requirements
- R1: After reset the status byte reads 00h, `miso` and `miso_en` are low, and every array byte reads FFh.
- R2: Bus mode 0 is used. `mosi` is sampled on the rising `sck` edge with the most significant bit first, and `miso` changes only after a falling `sck` edge. The opcodes are 06h set-latch, 04h clear-latch, 05h read-status, 01h write-status, 03h read and 02h write. Status bit 0 is busy, bit 1 is the write-enable latch, bits 3:2 are the protection bits, and bits 7:4 read 0.
- R3: The set-latch and clear-latch opcodes take effect only when select rises after exactly 8 clocks. With any other count the latch is left unchanged.
- R4: A write or write-status command starts a programming cycle only when select rises after a clock count that is a multiple of 8, and only with at least one data byte. Otherwise the command is discarded and the latch is kept.
- R5: A write or write-status command issued while the write-enable latch is clear starts no cycle and changes no array byte.
- R6: The protection bits select the protected region. 00 protects none, 01 protects the top quarter (180h-1FFh at 512 bytes), 10 protects the top half (100h-1FFh), and 11 protects the whole array. A write whose address is in that region starts no cycle and leaves the latch set.
- R7: While busy, read, write and write-status commands are ignored, with a read returning 00h, and the running cycle completes unchanged. Read-status still works and shows bit 0 set.
- R8: When the cycle ends, busy and the write-enable latch both clear, and the buffered data (or the new protection bits) become visible.
- R9: Write data bytes fill one 16-byte page. The address wraps inside the page, so a later byte lands on the low addresses of the same page.
- R10: A read returns consecutive bytes from the given address, wraps from the last byte to 000h, and may be ended at any bit with no effect on state.
- R11: With 512 bytes, address bit 8 is carried in opcode bit 3 (0Bh reads and 0Ah writes the upper half).
- R12: A select fall while `sck` is high starts no frame, and the clocks that follow are ignored. Pulling `hold_n` low while `sck` is low freezes the frame until it rises again, and `sck` edges in between are ignored. `hold_n` changes while `sck` is high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock |
| cs_n | input | 1 | Active-low select |
| mosi | input | 1 | Serial data into the block |
| hold_n | input | 1 | Active-low pause of the current frame |
| miso | output | 1 | Serial data out of the block |
| miso_en | output | 1 | High while a frame is selected and not paused |

## Verification
The hardest situation to reach is a command that arrives in the middle of a running programming cycle. Reaching it takes a fully accepted write, then a second frame started well before the counter expires, with the result read back only after the cycle ends. The bench runs this with a cycle long enough to hold a complete read frame and a complete write frame. It then checks that the first page was committed unchanged and the second address still reads FFh. Random writes of 1 to 18 bytes mixed with protection changes then keep hitting the page-wrap and protected-range corners.

// File: rtl/eeprom_spi_pkg.sv
package eeprom_spi_pkg;

    typedef enum logic [2:0] {
        K_NONE, K_WREN, K_WRDI, K_RDSR, K_WRSR, K_READ, K_WRITE
    } cmd_kind_e;

    localparam logic [7:0] OP_SETL  = 8'h06;
    localparam logic [7:0] OP_CLRL  = 8'h04;
    localparam logic [7:0] OP_RDST  = 8'h05;
    localparam logic [7:0] OP_WRST  = 8'h01;
    localparam logic [7:0] OP_RD    = 8'h03;
    localparam logic [7:0] OP_WR    = 8'h02;

    // hi: the array needs a ninth address bit, carried in opcode bit 3
    function automatic cmd_kind_e decode_op(input logic [7:0] op, input logic hi);
        logic [7:0] m;
        m = hi ? (op & 8'hF7) : op;
        if (op == OP_SETL) return K_WREN;
        if (op == OP_CLRL) return K_WRDI;
        if (op == OP_RDST) return K_RDSR;
        if (op == OP_WRST) return K_WRSR;
        if (m == OP_RD)    return K_READ;
        if (m == OP_WR)    return K_WRITE;
        return K_NONE;
    endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int             N   = 4,
    parameter logic [N-1:0]   RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_i,
    output logic [N-1:0] lvl_o
);
    for (genvar g = 0; g < N; g++) begin : g_pin
        logic s1_q, s2_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1_q <= RST[g];
                s2_q <= RST[g];
            end else begin
                s1_q <= pin_i[g];
                s2_q <= s1_q;
            end
        end
        assign lvl_o[g] = s2_q;
    end
endmodule

// File: rtl/eeprom_protect_map.sv
module eeprom_protect_map (
    input  logic [1:0] bp_i,
    input  logic [1:0] addr_top_i,
    output logic       hit_o
);
    always_comb begin
        unique case (bp_i)
            2'b00:   hit_o = 1'b0;
            2'b01:   hit_o = (addr_top_i == 2'b11);
            2'b10:   hit_o = addr_top_i[1];
            default: hit_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/eeprom_page_store.sv
module eeprom_page_store #(
    parameter int ADDR_W = 9,
    parameter int PAGE_W = 4,
    localparam int DEPTH = 1 << ADDR_W,
    localparam int PAGE  = 1 << PAGE_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        commit_i,
    input  logic [ADDR_W-PAGE_W-1:0]    page_i,
    input  logic [PAGE-1:0][7:0]        data_i,
    input  logic [PAGE-1:0]             valid_i,
    input  logic [ADDR_W-1:0]           rd_addr_i,
    output logic [7:0]                  rd_data_o
);
    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
        end else if (commit_i) begin
            for (int j = 0; j < PAGE; j++) begin
                if (valid_i[j]) mem_q[{page_i, PAGE_W'(j)}] <= data_i[j];
            end
        end
    end

    assign rd_data_o = mem_q[rd_addr_i];

    // a committed page always carries at least one data byte
    assert_commit_has_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i |-> (valid_i != '0));
endmodule

// File: rtl/eeprom_spi_ctrl.sv
module eeprom_spi_ctrl
    import eeprom_spi_pkg::*;
#(
    parameter int MEM_BYTES  = 512,
    parameter int PAGE_BYTES = 16,
    parameter int WC_CYCLES  = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic mosi,
    input  logic hold_n,
    output logic miso,
    output logic miso_en
);
    localparam int   ADDR_W  = $clog2(MEM_BYTES);
    localparam int   PAGE_W  = $clog2(PAGE_BYTES);
    localparam int   TMR_W   = $clog2(WC_CYCLES + 1);
    localparam logic HI_ADDR = (ADDR_W > 8);

    typedef struct packed {
        logic                        frame;
        logic                        hold;
        logic                        sck_p;
        logic                        cs_p;
        logic [2:0]                  bit_cnt;
        logic [4:0]                  byte_cnt;
        logic [6:0]                  sh;
        logic [7:0]                  op;
        cmd_kind_e                   kind;
        logic                        ign;
        logic [ADDR_W-1:0]           addr;
        logic [7:0]                  tx;
        logic                        miso;
        logic                        wel;
        logic                        wip;
        logic [1:0]                  bp;
        logic [1:0]                  bp_new;
        logic                        sr_cyc;
        logic [ADDR_W-1:0]           wpage;
        logic [TMR_W-1:0]            tmr;
        logic [PAGE_BYTES-1:0][7:0]  pbuf;
        logic [PAGE_BYTES-1:0]       pval;
    } st_t;

    st_t s_d, s_q;

    logic [3:0]        pin_lvl;
    logic              sck_s, cs_s, mosi_s, hold_s;
    logic              sck_rise, sck_fall, cs_rise, cs_fall;
    logic [ADDR_W-1:0] rd_addr;
    logic [7:0]        rd_data;
    logic              prot_hit, prot_busy;
    logic              commit;

    spi_pin_sync #(.N(4), .RST(4'b1010)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i ({hold_n, mosi, cs_n, sck}),
        .lvl_o (pin_lvl)
    );

    assign sck_s    = pin_lvl[0];
    assign cs_s     = pin_lvl[1];
    assign mosi_s   = pin_lvl[2];
    assign hold_s   = pin_lvl[3];
    assign sck_rise = sck_s & ~s_q.sck_p;
    assign sck_fall = ~sck_s & s_q.sck_p;
    assign cs_rise  = cs_s & ~s_q.cs_p;
    assign cs_fall  = ~cs_s & s_q.cs_p;

    eeprom_protect_map u_prot_new (
        .bp_i       (s_q.bp),
        .addr_top_i (s_q.addr[ADDR_W-1 -: 2]),
        .hit_o      (prot_hit)
    );

    eeprom_protect_map u_prot_busy (
        .bp_i       (s_q.bp),
        .addr_top_i (s_q.wpage[ADDR_W-1 -: 2]),
        .hit_o      (prot_busy)
    );

    assign commit = s_q.wip && (s_q.tmr == '0) && !s_q.sr_cyc;

    eeprom_page_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit_i  (commit),
        .page_i    (s_q.wpage[ADDR_W-1:PAGE_W]),
        .data_i    (s_q.pbuf),
        .valid_i   (s_q.pval),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data)
    );

    function automatic logic [ADDR_W-1:0] join_addr(input logic [7:0] op, input logic [7:0] lo);
        logic [8:0] e;
        e = {op[3], lo};
        return e[ADDR_W-1:0];
    endfunction

    always_comb begin
        logic [7:0] status;
        logic [7:0] byte_in;
        cmd_kind_e  k;

        s_d     = s_q;
        rd_addr = s_q.addr;
        status  = {4'b0, s_q.bp, s_q.wel, s_q.wip};
        byte_in = {s_q.sh, mosi_s};
        k       = K_NONE;

        s_d.sck_p = sck_s;
        s_d.cs_p  = cs_s;

        // pause pin is honoured only while the serial clock is low
        if (s_q.frame && !sck_s) s_d.hold = ~hold_s;

        if (s_q.frame && !s_q.hold && sck_rise) begin
            s_d.sh      = {s_q.sh[5:0], mosi_s};
            s_d.bit_cnt = s_q.bit_cnt + 3'd1;
            if (s_q.bit_cnt == 3'd7) begin
                if (s_q.byte_cnt != '1) s_d.byte_cnt = s_q.byte_cnt + 5'd1;
                if (s_q.byte_cnt == '0) begin
                    k        = decode_op(byte_in, HI_ADDR);
                    s_d.op   = byte_in;
                    s_d.kind = k;
                    s_d.ign  = s_q.wip && (k == K_READ || k == K_WRITE || k == K_WRSR);
                    s_d.tx   = (k == K_RDSR) ? status : 8'h00;
                    if (k == K_WRITE && !s_q.wip) s_d.pval = '0;
                end else if (!s_q.ign) begin
                    unique case (s_q.kind)
                        K_RDSR: s_d.tx = status;
                        K_READ: begin
                            if (s_q.byte_cnt == 5'd1) rd_addr = join_addr(s_q.op, byte_in);
                            s_d.tx   = rd_data;
                            s_d.addr = rd_addr + 1'b1;
                        end
                        K_WRITE: begin
                            if (s_q.byte_cnt == 5'd1) begin
                                s_d.addr = join_addr(s_q.op, byte_in);
                            end else begin
                                s_d.pbuf[s_q.addr[PAGE_W-1:0]] = byte_in;
                                s_d.pval[s_q.addr[PAGE_W-1:0]] = 1'b1;
                                s_d.addr = {s_q.addr[ADDR_W-1:PAGE_W], s_q.addr[PAGE_W-1:0] + 1'b1};
                            end
                        end
                        K_WRSR: if (s_q.byte_cnt == 5'd1) s_d.bp_new = byte_in[3:2];
                        default: ;
                    endcase
                end
            end
        end

        if (s_q.frame && !s_q.hold && sck_fall) s_d.miso = s_q.tx[3'd7 - s_q.bit_cnt];

        // frame open: only a clean select fall with the clock low
        if (!s_q.frame && cs_fall && !sck_s) begin
            s_d.frame    = 1'b1;
            s_d.hold     = 1'b0;
            s_d.bit_cnt  = '0;
            s_d.byte_cnt = '0;
            s_d.ign      = 1'b0;
            s_d.kind     = K_NONE;
            s_d.tx       = '0;
        end

        // frame close: commit only on a byte boundary
        if (s_q.frame && cs_rise) begin
            s_d.frame = 1'b0;
            s_d.hold  = 1'b0;
            if (s_q.bit_cnt == '0 && !s_q.ign) begin
                unique case (s_q.kind)
                    K_WREN: if (s_q.byte_cnt == 5'd1) s_d.wel = 1'b1;
                    K_WRDI: if (s_q.byte_cnt == 5'd1) s_d.wel = 1'b0;
                    K_WRSR: if (s_q.byte_cnt == 5'd2 && s_q.wel && !s_q.wip) begin
                        s_d.wip    = 1'b1;
                        s_d.sr_cyc = 1'b1;
                        s_d.tmr    = TMR_W'(WC_CYCLES - 1);
                    end
                    K_WRITE: if (s_q.byte_cnt >= 5'd3 && s_q.wel && !s_q.wip && !prot_hit) begin
                        s_d.wip    = 1'b1;
                        s_d.sr_cyc = 1'b0;
                        s_d.wpage  = s_q.addr;
                        s_d.tmr    = TMR_W'(WC_CYCLES - 1);
                    end
                    default: ;
                endcase
            end
        end

        // programming cycle counter
        if (s_q.wip) begin
            if (s_q.tmr == '0) begin
                s_d.wip = 1'b0;
                s_d.wel = 1'b0;
                if (s_q.sr_cyc) s_d.bp = s_q.bp_new;
            end else begin
                s_d.tmr = s_q.tmr - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.sck_p <= 1'b0;
            s_q.cs_p  <= 1'b1;
            s_q.kind  <= K_NONE;
        end else begin
            s_q <= s_d;
        end
    end

    assign miso    = s_q.miso;
    assign miso_en = s_q.frame & ~s_q.hold;

    assert_done_clears_wel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.wip) |-> !s_q.wel);

    assert_start_needs_wel_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.wip) |-> $past(s_q.wel));

    assert_start_on_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.wip) |-> ($past(cs_rise) && $past(s_q.bit_cnt) == 3'd0));

    assert_cycle_undisturbed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.wip && s_q.tmr != '0) |=> (s_q.wip && $stable(s_q.wpage)
                                        && $stable(s_q.pval) && $stable(s_q.pbuf)));

    assert_no_protected_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.wip && !s_q.sr_cyc) |-> !prot_busy);

    assert_miso_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.miso != $past(s_q.miso)) |-> $past(sck_fall));
endmodule

// File: tb/eeprom_spi_ctrl_test.sv
module eeprom_spi_ctrl_test;
    localparam int HALF = 6;
    localparam int WC   = 2000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, hold_n = 1'b1;
    logic miso, miso_en;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    logic [7:0] mem_m [512];
    logic       wel_m;
    logic [1:0] bp_m;
    logic [7:0] rbuf [32];
    logic [7:0] wbuf [32];

    always #2 clk = ~clk;

    eeprom_spi_ctrl #(.MEM_BYTES(512), .PAGE_BYTES(16), .WC_CYCLES(WC)) uut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
        .hold_n(hold_n), .miso(miso), .miso_en(miso_en)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected<190000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    function automatic logic prot_m(input logic [8:0] a, input logic [1:0] bp);
        if (bp == 2'b11) return 1'b1;
        if (bp == 2'b10) return a >= 9'h100;
        if (bp == 2'b01) return a >= 9'h180;
        return 1'b0;
    endfunction

    task automatic bit_io(input logic b, output logic r);
        mosi = b; w(HALF); r = miso; sck = 1'b1; w(HALF); sck = 1'b0;
    endtask

    task automatic xfer(input logic [7:0] b, output logic [7:0] r);
        for (int i = 7; i >= 0; i--) begin
            logic x;
            bit_io(b[i], x); r[i] = x;
        end
    endtask

    task automatic cs_lo; sck = 1'b0; cs_n = 1'b0; w(HALF); endtask
    task automatic cs_hi; w(HALF); cs_n = 1'b1; w(3 * HALF); endtask

    task automatic cmd1(input logic [7:0] op);
        logic [7:0] r;
        cs_lo; xfer(op, r); cs_hi;
    endtask

    task automatic rdsr(output logic [7:0] s);
        logic [7:0] r;
        cs_lo; xfer(8'h05, r); xfer(8'h00, s); cs_hi;
    endtask

    task automatic wait_idle;
        logic [7:0] s;
        for (int i = 0; i < 100; i++) begin
            rdsr(s);
            if (!s[0]) return;
        end
        chk("R8 cycle end", 8'h01, 8'h00);
    endtask

    task automatic do_read(input logic [8:0] a, input int n);
        logic [7:0] r;
        cs_lo; xfer({4'b0000, a[8], 3'b011}, r); xfer(a[7:0], r);
        for (int i = 0; i < n; i++) xfer(8'h00, rbuf[i]);
        cs_hi;
    endtask

    task automatic do_write(input logic [8:0] a, input int n, input int extra);
        logic [7:0] r;
        logic x;
        cs_lo; xfer({4'b0000, a[8], 3'b010}, r); xfer(a[7:0], r);
        for (int i = 0; i < n; i++) xfer(wbuf[i], r);
        for (int i = 0; i < extra; i++) bit_io(1'b1, x);
        cs_hi;
    endtask

    task automatic set_bp(input logic [1:0] bp);
        logic [7:0] r;
        cmd1(8'h06);
        cs_lo; xfer(8'h01, r); xfer({4'b0, bp, 2'b00}, r); cs_hi;
        wait_idle;
        bp_m = bp; wel_m = 1'b0;
    endtask

    // model-checked write: returns after the cycle if one starts
    task automatic model_write(input logic [8:0] a, input int n);
        logic go;
        go = wel_m && (n >= 1) && !prot_m(a, bp_m);
        do_write(a, n, 0);
        if (go) begin
            for (int i = 0; i < n; i++) begin
                logic [3:0] lo;
                lo = a[3:0] + 4'(i);
                mem_m[{a[8:4], lo}] = wbuf[i];
            end
            wel_m = 1'b0;
            wait_idle;
        end
    endtask

    initial begin
        logic [7:0] s, r;
        logic x;
        int unsigned seed;
        seed = 32'd12345;
        for (int i = 0; i < 512; i++) mem_m[i] = 8'hFF;
        wel_m = 1'b0; bp_m = 2'b00;
        w(10); rst_n = 1'b1; w(5);

        // R1 reset state
        chk("R1 miso", {7'b0, miso}, 8'h00);
        chk("R1 miso_en", {7'b0, miso_en}, 8'h00);
        rdsr(s); chk("R1 status", s, 8'h00);
        do_read(9'h000, 1); chk("R1 blank array", rbuf[0], 8'hFF);

        // R3 latch only on exact 8 clocks
        cs_lo; for (int i = 6; i >= 0; i--) bit_io(i == 2 || i == 1, x); cs_hi;
        rdsr(s); chk("R3 seven clocks", s, 8'h00);
        cs_lo; xfer(8'h06, r); bit_io(1'b0, x); cs_hi;
        rdsr(s); chk("R3 nine clocks", s, 8'h00);
        cmd1(8'h06); rdsr(s); chk("R3 R2 set latch", s, 8'h02);
        cmd1(8'h04); rdsr(s); chk("R3 clear latch", s, 8'h00);

        // R5 write with latch clear
        wbuf[0] = 8'hAA;
        do_write(9'h010, 1, 0);
        rdsr(s); chk("R5 no cycle", s, 8'h00);
        do_read(9'h010, 1); chk("R5 array kept", rbuf[0], 8'hFF);

        // R9 R11 R7 page wrap in upper half, busy filtering
        cmd1(8'h06);
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
        do_write(9'h1FE, 3, 0);
        rdsr(s); chk("R7 busy status", s, 8'h03);
        do_read(9'h1FE, 1); chk("R7 read ignored", rbuf[0], 8'h00);
        wbuf[0] = 8'h55; do_write(9'h020, 1, 0);
        wait_idle;
        rdsr(s); chk("R8 latch cleared", s, 8'h00);
        do_read(9'h1FE, 2);
        chk("R11 byte 1FE", rbuf[0], 8'h11);
        chk("R11 byte 1FF", rbuf[1], 8'h22);
        do_read(9'h1F0, 1); chk("R9 wrap to 1F0", rbuf[0], 8'h33);
        do_read(9'h020, 1); chk("R7 busy write dropped", rbuf[0], 8'hFF);
        mem_m[9'h1FE] = 8'h11; mem_m[9'h1FF] = 8'h22; mem_m[9'h1F0] = 8'h33;

        // R10 sequential read wrapping past the top
        do_read(9'h1FF, 3);
        chk("R10 last byte", rbuf[0], 8'h22);
        chk("R10 wrap to 000", rbuf[1], 8'hFF);

        // R4 extra bits discard the write
        cmd1(8'h06);
        wbuf[0] = 8'h77; do_write(9'h030, 1, 3);
        rdsr(s); chk("R4 off-boundary", s, 8'h02);
        do_write(9'h030, 0, 0);
        rdsr(s); chk("R4 no data byte", s, 8'h02);
        do_read(9'h030, 1); chk("R4 array kept", rbuf[0], 8'hFF);
        cmd1(8'h04);

        // R6 protection quarter
        set_bp(2'b01);
        rdsr(s); chk("R6 bp written", s, 8'h04);
        cmd1(8'h06);
        wbuf[0] = 8'h99; do_write(9'h180, 1, 0);
        rdsr(s); chk("R6 protected rejected", s, 8'h06);
        wel_m = 1'b1;
        wbuf[0] = 8'h5A; model_write(9'h17F, 1);
        do_read(9'h17F, 1); chk("R6 unprotected written", rbuf[0], 8'h5A);
        do_read(9'h180, 1); chk("R6 protected kept", rbuf[0], 8'hFF);

        // R10 read cut mid-byte leaves state
        cs_lo; xfer(8'h03, r); xfer(8'h00, r); for (int i = 0; i < 3; i++) bit_io(1'b0, x); cs_hi;
        rdsr(s); chk("R10 early end", s, 8'h04);

        // R12 pause during a read byte
        cs_lo; xfer(8'h03, r); xfer(8'h7F, r);
        for (int i = 7; i >= 4; i--) begin bit_io(1'b0, x); r[i] = x; end
        hold_n = 1'b0; w(HALF);
        for (int i = 0; i < 3; i++) begin sck = 1'b1; w(HALF); sck = 1'b0; w(HALF); end
        chk("R12 paused output off", {7'b0, miso_en}, 8'h00);
        hold_n = 1'b1; w(HALF);
        for (int i = 3; i >= 0; i--) begin bit_io(1'b0, x); r[i] = x; end
        cs_hi;
        chk("R12 data across pause", r, mem_m[9'h07F]);

        // R12 pause toggled while clock high has no effect
        cs_lo;
        for (int i = 7; i >= 0; i--) begin
            mosi = (i == 2 || i == 1); w(HALF); sck = 1'b1;
            if (i == 4) begin w(1); hold_n = 1'b0; w(2); hold_n = 1'b1; w(HALF - 3); end
            else w(HALF);
            sck = 1'b0;
        end
        cs_hi;
        rdsr(s); chk("R12 high-clock pause ignored", s, 8'h06);
        cmd1(8'h04);

        // R12 select falling with clock high
        sck = 1'b1; w(HALF); cs_n = 1'b0; w(HALF); sck = 1'b0;
        for (int i = 7; i >= 0; i--) bit_io(i == 2 || i == 1, x);
        cs_hi;
        rdsr(s); chk("R12 bad select ignored", s, 8'h04);
        wel_m = 1'b0;

        // random mix against the model
        for (int it = 0; it < 20; it++) begin
            int act, n;
            logic [8:0] a;
            act = $urandom(seed) % 4; seed = seed + 7;
            a = 9'($urandom());
            if (act == 0) begin
                set_bp(2'($urandom()));
                rdsr(s); chk("R6 random bp", s, {4'b0, bp_m, 2'b00});
            end else if (act == 1) begin
                n = 1 + int'($urandom() % 6);
                do_read(a, n);
                for (int i = 0; i < n; i++) chk("R10 random read", rbuf[i], mem_m[9'(a + 9'(i))]);
            end else begin
                n = 1 + int'($urandom() % 18);
                for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom());
                if ($urandom() % 4 != 0) begin cmd1(8'h06); wel_m = 1'b1; end
                model_write(a, n);
                rdsr(s); chk("R8 R9 random status", s, {4'b0, bp_m, wel_m, 1'b0});
                do_read({a[8:4], 4'h0}, 16);
                for (int i = 0; i < 16; i++) chk("R9 random page", rbuf[i], mem_m[{a[8:4], 4'(i)}]);
                if (wel_m) begin cmd1(8'h04); wel_m = 1'b0; end
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule